// File: doc/BRIEF.md
# Five-Way Redundant Bit Voter with Sticky Module Exclusion

This block merges the single-bit results of five identical redundant modules into one system bit. Every module result is compared with the voted bit. A module that disagrees is flagged on the next clock edge, and from then on it no longer takes part in the vote. The per-module disagreement bits are exported so that a recovery agent elsewhere can see which copy is wrong. That agent clears a module's flag through a dedicated clear line once the copy agrees again.

The vote is always taken by one five-input majority gate. A remapping stage sits in front of it. When modules are excluded, the stage forces one slot to 0 and another slot to 1. The two forced slots cancel each other, so the gate behaves as a three-input majority of the slots that were not forced. Zero, one or two exclusions are handled this way. With three or more modules excluded the block raises an overload indication, and the voted bit is then not specified.

Top module: `penta_voter`

## Requirements
- R1: A synchronous active-high reset clears all five exclusion flags and deasserts overload. The flags are therefore all 0 at the start of operation and stay 0 while no module disagrees.
- R2: With no module excluded, the voted bit is 1 exactly when at least three of the five module bits are 1.
- R3: Mismatch bit i (bit i belongs to module i) equals module bit i XOR the voted bit in the same cycle. This holds for excluded modules too.
- R4: A mismatch bit of 1 sets that module's exclusion flag at the next rising clock edge. The flag then stays 1 while that module's clear line is low.
- R5: Clear line i drives flag i to 0 at the next edge and takes priority over a mismatch in the same cycle. It affects no other module's flag.
- R6: With exactly one module excluded, that module's slot is forced to 0. The slot of the highest-index module that is not excluded is forced to 1. The voted bit is therefore the majority of the three remaining modules, and the highest-index non-excluded module has no influence.
- R7: With exactly two modules excluded, the lower-index excluded slot is forced to 0 and the higher-index one to 1. The voted bit is the majority of the three non-excluded modules.
- R8: Overload is 1 exactly when three or more exclusion flags are set. With two or fewer set, it is 0.
- R9: If at most two modules are corrupted in the same cycle while none is excluded, the voted bit equals the fault-free value. The same holds if one further module is corrupted while at most two are excluded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the exclusion flags |
| rst | input | 1 | Synchronous active-high reset |
| modIn | input | 5 | Result bit of each redundant module, bit i = module i |
| clrExcl | input | 5 | Per-module clear of the exclusion flag |
| voted | output | 1 | Voted system bit |
| mismatch | output | 5 | Per-module disagreement with the voted bit |
| exclFlag | output | 5 | Sticky exclusion flags |
| overload | output | 1 | Three or more modules excluded |

## Verification
The vote is exercised first with all modules agreeing. It is then tried with a single corrupted module, with two modules corrupted in one cycle, and with a further fault arriving after two exclusions; these show that degraded voting still returns the fault-free value. Some patterns are chosen so that the plain five-way majority and the remapped three-way majority disagree. One such pattern has the highest-index non-excluded module voting against the other three, which confirms that the forced slots sit exactly where R6 and R7 place them. Clear lines are raised in the same cycle as a live mismatch to separate clear priority from set, and a reset with flags set shows that all state returns to zero.

// File: rtl/voter_pkg.sv
package voter_pkg;
  // number of redundant copies feeding the voter
  localparam int MOD_CNT = 5;
  // slots needed for a plain majority among all copies
  localparam int MAJ_LIMIT = MOD_CNT / 2 + 1;
  // how many exclusions the pairwise remap can absorb
  localparam int MAX_ABSORB = MOD_CNT - MAJ_LIMIT;
  localparam int CNT_W = $clog2(MOD_CNT + 1);
  localparam int IDX_W = $clog2(MOD_CNT);

  // strobes from the exclusion control to the voting datapath
  typedef struct packed {
    logic [MOD_CNT-1:0] forceLo;
    logic [MOD_CNT-1:0] forceHi;
    logic               overload;
  } remapCtl_t;
endpackage

// File: rtl/voter_excl_ctrl.sv
module voter_excl_ctrl
  import voter_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [MOD_CNT-1:0] mismatch,
  input  logic [MOD_CNT-1:0] clrExcl,
  output logic [MOD_CNT-1:0] exclFlag,
  output remapCtl_t          remapCtl
);

  logic [MOD_CNT-1:0] exclQ;
  logic [CNT_W-1:0]   exclCnt;
  logic [IDX_W-1:0]   hiFree;
  logic [IDX_W-1:0]   loExcl;
  logic [IDX_W-1:0]   hiExcl;

  // one sticky flag per module, clear beats set
  for (genvar i = 0; i < MOD_CNT; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)              exclQ[i] <= 1'b0;
      else if (clrExcl[i])  exclQ[i] <= 1'b0;
      else if (mismatch[i]) exclQ[i] <= 1'b1;
    end

    // R4
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
      (mismatch[i] && !clrExcl[i]) |=> exclFlag[i]);

    // R4
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (exclFlag[i] && !clrExcl[i]) |=> exclFlag[i]);

    // R5
    flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
      clrExcl[i] |=> !exclFlag[i]);
  end

  assign exclFlag = exclQ;
  assign exclCnt  = CNT_W'($countones(exclQ));

  // locate the slots that receive the forced constants
  always_comb begin
    hiFree = '0;
    loExcl = '0;
    hiExcl = '0;
    for (int i = 0; i < MOD_CNT; i++) begin
      if (!exclQ[i]) hiFree = IDX_W'(i);
      if (exclQ[i])  hiExcl = IDX_W'(i);
    end
    for (int i = MOD_CNT - 1; i >= 0; i--) begin
      if (exclQ[i]) loExcl = IDX_W'(i);
    end
  end

  always_comb begin
    remapCtl          = '0;
    remapCtl.overload = (exclCnt > CNT_W'(MAX_ABSORB));
    if (exclCnt == CNT_W'(1)) begin
      remapCtl.forceLo         = exclQ;
      remapCtl.forceHi[hiFree] = 1'b1;
    end else if (exclCnt == CNT_W'(2)) begin
      remapCtl.forceLo[loExcl] = 1'b1;
      remapCtl.forceHi[hiExcl] = 1'b1;
    end else if (remapCtl.overload) begin
      remapCtl.forceLo = exclQ;
    end
  end

  // R1
  quiet_stays_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (exclFlag == '0 && mismatch == '0) |=> (exclFlag == '0));

endmodule

// File: rtl/voter_datapath.sv
module voter_datapath
  import voter_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [MOD_CNT-1:0] modIn,
  input  remapCtl_t          remapCtl,
  output logic               voted,
  output logic [MOD_CNT-1:0] mismatch
);

  logic [MOD_CNT-1:0] slotBit;
  logic [CNT_W-1:0]   onesCnt;

  // remap stage: a forced pair cancels in the majority count
  for (genvar i = 0; i < MOD_CNT; i++) begin : g_slot
    always_comb begin
      if (remapCtl.forceHi[i])      slotBit[i] = 1'b1;
      else if (remapCtl.forceLo[i]) slotBit[i] = 1'b0;
      else                          slotBit[i] = modIn[i];
    end
  end

  assign onesCnt  = CNT_W'($countones(slotBit));
  assign voted    = (onesCnt >= CNT_W'(MAJ_LIMIT));
  assign mismatch = modIn ^ {MOD_CNT{voted}};

  // R6 R7
  forced_pair_chk: assert property (@(posedge clk) disable iff (rst)
    !remapCtl.overload |->
      ($countones(remapCtl.forceLo) == $countones(remapCtl.forceHi)));

  // R6
  forced_disjoint_chk: assert property (@(posedge clk) disable iff (rst)
    (remapCtl.forceLo & remapCtl.forceHi) == '0);

  // R7
  forced_single_hi_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(remapCtl.forceHi));

endmodule

// File: rtl/penta_voter.sv
module penta_voter
  import voter_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [MOD_CNT-1:0] modIn,
  input  logic [MOD_CNT-1:0] clrExcl,
  output logic               voted,
  output logic [MOD_CNT-1:0] mismatch,
  output logic [MOD_CNT-1:0] exclFlag,
  output logic               overload
);

  remapCtl_t remapCtl;

  voter_excl_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .mismatch (mismatch),
    .clrExcl  (clrExcl),
    .exclFlag (exclFlag),
    .remapCtl (remapCtl)
  );

  voter_datapath u_dp (
    .clk      (clk),
    .rst      (rst),
    .modIn    (modIn),
    .remapCtl (remapCtl),
    .voted    (voted),
    .mismatch (mismatch)
  );

  assign overload = remapCtl.overload;

endmodule

// File: tb/tb_penta_voter.sv
module tb_penta_voter;

  logic       clk = 1'b0;
  logic       rst;
  logic [4:0] modIn;
  logic [4:0] clrExcl;
  logic       voted;
  logic [4:0] mismatch;
  logic [4:0] exclFlag;
  logic       overload;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  penta_voter dut (
    .clk      (clk),
    .rst      (rst),
    .modIn    (modIn),
    .clrExcl  (clrExcl),
    .voted    (voted),
    .mismatch (mismatch),
    .exclFlag (exclFlag),
    .overload (overload)
  );

  // {clr, modIn, expVoted, expMismatch, expExclBefore, expOverload}
  localparam int NV = 15;
  localparam logic [21:0] VEC [NV] = '{
    {5'b00000, 5'b11111, 1'b1, 5'b00000, 5'b00000, 1'b0}, // R2 all agree
    {5'b00000, 5'b00000, 1'b0, 5'b00000, 5'b00000, 1'b0}, // R2
    {5'b00000, 5'b00010, 1'b0, 5'b00010, 5'b00000, 1'b0}, // R9 single fault
    {5'b00000, 5'b11111, 1'b1, 5'b00000, 5'b00010, 1'b0}, // R4 flag set
    {5'b11000, 5'b11010, 1'b0, 5'b11010, 5'b00010, 1'b0}, // R6 module 4 ignored
    {5'b00010, 5'b00000, 1'b0, 5'b00000, 5'b00010, 1'b0}, // R5 clear priority seen
    {5'b00000, 5'b10100, 1'b0, 5'b10100, 5'b00000, 1'b0}, // R9 double fault
    {5'b00000, 5'b01011, 1'b1, 5'b10100, 5'b10100, 1'b0}, // R7 R3 excluded mismatch
    {5'b00000, 5'b01010, 1'b1, 5'b10101, 5'b10100, 1'b0}, // R9 third fault
    {5'b11111, 5'b00000, 1'b0, 5'b00000, 5'b10101, 1'b1}, // R8 overload
    {5'b00000, 5'b00111, 1'b1, 5'b11000, 5'b00000, 1'b0}, // R2 R3
    {5'b11001, 5'b11001, 1'b0, 5'b11001, 5'b11000, 1'b0}, // R7 vs plain majority
    {5'b00000, 5'b10000, 1'b0, 5'b10000, 5'b00000, 1'b0}, // R4
    {5'b11001, 5'b11001, 1'b0, 5'b11001, 5'b10000, 1'b0}, // R6 module 3 ignored
    {5'b00000, 5'b11111, 1'b1, 5'b00000, 5'b00000, 1'b0}  // R5 all cleared
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    #(20 * 5000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    modIn = '0;
    clrExcl = '0;
    repeat (2) @(negedge clk);
    check("R1 flags after reset", {3'b0, exclFlag}, 8'h00);
    check("R1 overload after reset", {7'b0, overload}, 8'h00);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      clrExcl = VEC[k][21:17];
      modIn   = VEC[k][16:12];
      #2;
      check($sformatf("R2/R6/R7/R9 voted vec%0d", k), {7'b0, voted}, {7'b0, VEC[k][11]});
      check($sformatf("R3 mismatch vec%0d", k), {3'b0, mismatch}, {3'b0, VEC[k][10:6]});
      check($sformatf("R4/R5 flags vec%0d", k), {3'b0, exclFlag}, {3'b0, VEC[k][5:1]});
      check($sformatf("R8 overload vec%0d", k), {7'b0, overload}, {7'b0, VEC[k][0]});
    end

    // R4: flag persists over several cycles while the module recovers
    @(negedge clk);
    clrExcl = '0;
    modIn = 5'b00001;
    @(negedge clk);
    modIn = 5'b00000;
    repeat (3) @(negedge clk);
    check("R4 sticky flag", {3'b0, exclFlag}, 8'h01);

    // R1: reset with a flag set returns all state to zero
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset clears flags", {3'b0, exclFlag}, 8'h00);
    check("R1 reset clears overload", {7'b0, overload}, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    check("R1 stays clear without mismatch", {3'b0, exclFlag}, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule